// File: doc/BRIEF.md
# Match-compare event timer

This block is a memory-mapped up-counter with a compare register. Software programs a target value, starts the counter, and receives a one-cycle interrupt pulse when the count arrives at that target. A small prescaler sits in front of the counter, so the count advances on every first, second, third or fourth system clock. An optional clear-on-match mode turns the counter into a periodic tick source. Without that mode, the counter runs freely and wraps.

Software zeroes the counter by writing to a clear register. The clear does not take effect at once. It lands two divided ticks after the write. Until then, a pending flag in the status register reads 1. The expected driver sequence has four steps: stop the counter, write the clear, program the match value, then poll the pending flag down before starting the counter again.

Top module: `match_timer`

## Requirements
- R1: After reset, every readable register returns 0, the counter is stopped, and `irq` is low.
- R2: The register map is as follows. Offset 0x00 is the match value (read/write, full width). Offset 0x04 is the count (read-only; writes have no effect). Offset 0x08 is control (bits [1:0]). Offset 0x10 is the divider (bits [1:0]). Offset 0x14 is status. Offset 0x0C and unmapped offsets read 0.
- R3: While control bit 0 is 1, the count rises by one on every divided tick. While control bit 0 is 0, the count holds its value.
- R4: A divider value n divides the count clock by n+1 (0 gives /1, 3 gives /4). Writing the divider restarts the prescaler phase, so the first tick comes on the (n+1)-th clock edge after the write edge.
- R5: With control bit 1 at 0, the count wraps from its all-ones value to 0.
- R6: With control bit 1 at 1, a count equal to the match value returns to 0 on the next tick instead of incrementing.
- R7: `irq` is a single-cycle pulse. It is high in exactly the cycle in which a counting step first makes the count equal to the match value, and never when counting is stopped.
- R8: A write to offset 0x0C, whatever its data, zeroes the count on the second divided tick after the write. A running count keeps advancing until then.
- R9: Status bit 10 reads 1 from the write edge of a clear until the clear lands, then reads 0. A new clear written while one is pending restarts the two-tick wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW (5) | Register byte offset |
| wdata | input | W (32) | Write data |
| we | input | 1 | Write strobe, one register write per cycle |
| rdata | output | W (32) | Read data for `addr`, combinational |
| irq | output | 1 | Match event pulse |

## Verification
Some properties are checked on every cycle. Each count change is either a +1 step or a return to zero. The count holds while the counter is stopped and no clear is pending. A falling pending flag always leaves the count at zero. Every `irq` pulse lasts one cycle, coincides with count equal to the match value, and follows a cycle in which counting was enabled. Other behaviours only the bench scenarios can show: the exact tick phase after a divider write, the landing cycle of a clear and its restart, all-ones wraparound (on a 12-bit instance), and the interrupt counts produced by mixes of divider, match value and clear-on-match.

// File: rtl/match_timer.sv
module match_timer #(
  parameter int W         = 32,
  parameter int AW        = 5,
  parameter int DW        = 2,
  parameter int CLR_TICKS = 2,
  parameter int PEND_BIT  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic          we,
  output logic [W-1:0]  rdata,
  output logic          irq
);

  localparam int PTW = (CLR_TICKS > 1) ? $clog2(CLR_TICKS) : 1;
  localparam logic [PTW-1:0] PT_LAST = PTW'(CLR_TICKS - 1);
  localparam logic [AW-1:0] A_MATCH = AW'(8'h00);
  localparam logic [AW-1:0] A_COUNT = AW'(8'h04);
  localparam logic [AW-1:0] A_CTRL  = AW'(8'h08);
  localparam logic [AW-1:0] A_CLR   = AW'(8'h0C);
  localparam logic [AW-1:0] A_DIV   = AW'(8'h10);
  localparam logic [AW-1:0] A_STAT  = AW'(8'h14);

  logic [W-1:0]   match_q, cnt_q, cnt_nxt;
  logic           run_q, com_q, pend_q, irq_q;
  logic [DW-1:0]  div_q, pcnt_q;
  logic [PTW-1:0] pt_q;
  logic           tick, step, clr_wr, div_wr, clr_done;

  assign tick     = (pcnt_q == div_q);
  assign step     = run_q && tick;
  assign clr_wr   = we && (addr == A_CLR);
  assign div_wr   = we && (addr == A_DIV);
  assign clr_done = pend_q && tick && (pt_q == PT_LAST) && !clr_wr;
  assign cnt_nxt  = (com_q && cnt_q == match_q) ? '0 : cnt_q + W'(1);
  assign irq      = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      run_q   <= 1'b0;
      com_q   <= 1'b0;
      div_q   <= '0;
    end else if (we) begin
      if (addr == A_MATCH) match_q <= wdata;
      if (addr == A_CTRL) begin
        run_q <= wdata[0];
        com_q <= wdata[1];
      end
      if (addr == A_DIV) div_q <= wdata[DW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pcnt_q <= '0;
    else if (div_wr) pcnt_q <= '0;
    else if (tick)   pcnt_q <= '0;
    else             pcnt_q <= pcnt_q + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pt_q   <= '0;
    end else if (clr_wr) begin
      pend_q <= 1'b1;
      pt_q   <= '0;
    end else if (pend_q && tick) begin
      if (pt_q == PT_LAST) pend_q <= 1'b0;
      else                 pt_q   <= pt_q + PTW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (clr_done)  cnt_q <= '0;
      else if (step) cnt_q <= cnt_nxt;
      irq_q <= step && !clr_done && (cnt_nxt == match_q) && (cnt_nxt != cnt_q);
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_MATCH: rdata = match_q;
      A_COUNT: rdata = cnt_q;
      A_CTRL:  rdata = {{(W-2){1'b0}}, com_q, run_q};
      A_DIV:   rdata = {{(W-DW){1'b0}}, div_q};
      A_STAT:  rdata[PEND_BIT] = pend_q;
      default: rdata = '0;
    endcase
  end

  // R3
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !pend_q && !clr_wr) |=> $stable(cnt_q));

  // R3
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + W'(1) || cnt_q == '0));

  // R8
  clear_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> (cnt_q == '0));

  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R7
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (cnt_q == $past(match_q)));

  // R7
  irq_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(run_q));

endmodule

// File: tb/tb_match_timer.sv
module tb_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        irq;

  logic [4:0]  addr_n = '0;
  logic [11:0] wdata_n = '0;
  logic        we_n = 1'b0;
  logic [11:0] rdata_n;
  logic        irq_n;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  match_timer dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
                   .we(we), .rdata(rdata), .irq(irq));

  match_timer #(.W(12)) dut_n (.clk(clk), .rst_n(rst_n), .addr(addr_n),
                   .wdata(wdata_n), .we(we_n), .rdata(rdata_n), .irq(irq_n));

  // {div, match, clear_on_match, cycles, expected count, expected irq pulses}
  typedef struct packed {
    logic [1:0]  div;
    logic [31:0] match;
    logic        com;
    logic [7:0]  cyc;
    logic [31:0] exp_cnt;
    logic [7:0]  exp_irq;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{2'd0, 32'd5, 1'b0, 8'd10, 32'd10, 8'd1},
    '{2'd0, 32'd3, 1'b1, 8'd10, 32'd2,  8'd2},
    '{2'd3, 32'd2, 1'b0, 8'd12, 32'd3,  8'd1},
    '{2'd1, 32'd4, 1'b1, 8'd10, 32'd0,  8'd1},
    '{2'd2, 32'd1, 1'b1, 8'd9,  32'd1,  8'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic edge1;
    @(posedge clk); #1;
  endtask

  task automatic clear_and_wait;
    logic [31:0] s;
    wr(5'h0C, 32'h0);
    rd(5'h14, s);
    while (s[10]) begin
      edge1();
      rd(5'h14, s);
    end
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int pulses;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    edge1();

    // R1: reset state
    rd(5'h00, v); chk("R1 match", v, 0);
    rd(5'h04, v); chk("R1 count", v, 0);
    rd(5'h08, v); chk("R1 ctrl", v, 0);
    rd(5'h10, v); chk("R1 div", v, 0);
    rd(5'h14, v); chk("R1 status", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    edge1(); edge1();
    rd(5'h04, v); chk("R1 stopped count", v, 0);

    // R2: readback and read-only count
    wr(5'h00, 32'h1234_5678); rd(5'h00, v); chk("R2 match rw", v, 32'h1234_5678);
    wr(5'h08, 32'hFFFF_FFFC); rd(5'h08, v); chk("R2 ctrl masked", v, 0);
    wr(5'h10, 32'hFFFF_FFFE); rd(5'h10, v); chk("R2 div masked", v, 2);
    wr(5'h04, 32'h0000_ABCD); rd(5'h04, v); chk("R2 count read-only", v, 0);
    rd(5'h0C, v); chk("R2 clear reads zero", v, 0);
    rd(5'h1C, v); chk("R2 unmapped reads zero", v, 0);

    // R3 R4 R6 R7: vector walk
    foreach (VECS[i]) begin
      wr(5'h08, 32'h0);
      clear_and_wait();
      rd(5'h04, v); chk("R8 cleared before run", v, 0);
      wr(5'h10, {30'b0, VECS[i].div});
      wr(5'h00, VECS[i].match);
      wr(5'h08, {30'b0, VECS[i].com, 1'b1});
      pulses = 0;
      for (int k = 0; k < int'(VECS[i].cyc); k++) begin
        edge1();
        if (irq) pulses++;
      end
      rd(5'h04, v); chk("R3 R4 R6 count after run", v, VECS[i].exp_cnt);
      chk("R7 irq pulse count", pulses, 32'(VECS[i].exp_irq));
    end

    // R3: stopped count holds, no irq
    wr(5'h08, 32'h0);
    rd(5'h04, v);
    begin
      logic [31:0] held;
      pulses = 0;
      for (int k = 0; k < 6; k++) begin
        edge1();
        if (irq) pulses++;
      end
      rd(5'h04, held);
      chk("R3 held while stopped", held, v);
      chk("R7 no irq while stopped", pulses, 0);
    end

    // R8 R9: clear while running at divide-by-1
    wr(5'h10, 32'h0);
    wr(5'h08, 32'h1);
    repeat (5) edge1();
    rd(5'h04, v); chk("R3 running count", v, 5);
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h04, v); chk("R8 count advances at clear write", v, 6);
    rd(5'h14, v); chk("R9 pending after write", v, 32'h400);
    edge1();
    rd(5'h04, v); chk("R8 count advances before landing", v, 7);
    rd(5'h14, v); chk("R9 pending one tick in", v, 32'h400);
    edge1();
    rd(5'h04, v); chk("R8 clear lands second tick", v, 0);
    rd(5'h14, v); chk("R9 pending drops", v, 0);
    edge1();
    rd(5'h04, v); chk("R8 counting resumes", v, 1);

    // R9: rewrite restarts the wait
    wr(5'h08, 32'h0);
    wr(5'h0C, 32'h0);
    wr(5'h0C, 32'h0);
    edge1();
    rd(5'h14, v); chk("R9 restart keeps pending", v, 32'h400);
    edge1();
    rd(5'h14, v); chk("R9 restart completes", v, 0);
    rd(5'h04, v); chk("R8 restart clears count", v, 0);

    // R5: wrap on a 12-bit instance
    @(negedge clk);
    addr_n = 5'h08; wdata_n = 12'h1; we_n = 1'b1;
    @(posedge clk); #1;
    we_n = 1'b0;
    pulses = 0;
    for (int k = 0; k < 4100; k++) begin
      edge1();
      if (irq_n) pulses++;
    end
    addr_n = 5'h04; #0.5;
    chk("R5 wrap count", {20'b0, rdata_n}, 4);
    chk("R7 irq at wrap onto match 0", pulses, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule